// File: doc/BRIEF.md
# Timer Interrupt Aggregator

This block gathers per-source interrupt flags from a bank of timer channels and presents them to the processor on up to three level-sensitive request lines. Each of the 32 sources has one flag bit and one mask bit. A single-cycle event pulse on a source sets its flag. The mask decides whether a set flag counts as pending.

Software changes state only through strobe registers on a simple register bus. One register sets mask bits, one clears mask bits, and one clears flags. A 1 in the written word acts on that bit and a 0 leaves it alone, so no read-modify-write is ever needed. The raw flags, the mask and the pending view (flags not masked) can each be read back.

A build parameter picks how sources are grouped onto the request lines. Source i belongs to timer channel i mod 8. Variant A gives channels 0 and 1 a line each and lets the remaining channels share a third line. Variant B gives channel 5 its own line, puts every other channel on a second line, and holds the third line low. The bus is plain: a write takes effect on the clock edge where `reg_wr_en` is high, and the read data follows `reg_addr` combinationally.

Top module: `tmr_irq_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the flags read zero and every request line is low.
- R2: Address 0 reads the raw flags, address 1 reads the mask, and address 2 reads the pending view, which is flags AND NOT mask.
- R3: A write to address 3 sets the mask bits that are 1 in the data. A write to address 4 clears them. Bits written as 0 keep their value.
- R4: A write to address 5 clears the flag bits that are 1 in the data. Bits written as 0 keep their value.
- R5: An event pulse sets its flag even while the source is masked. Unmasking a source whose flag is already stored raises its line in the next cycle.
- R6: If an event and a flag-clear write hit the same bit in the same cycle, the flag stays set.
- R7: Source i belongs to channel i mod 8. A line is high, in the cycle after the edge that changed the state, exactly while some pending source of its group exists.
- R8: With VARIANT=0, line 0 serves channel 0, line 1 serves channel 1, and line 2 serves channels 2 to 7.
- R9: With VARIANT=1, line 0 serves channel 5, line 1 serves channels 0 to 4 and 6 to 7, and line 2 stays low.
- R10: Addresses 3 to 7 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Write strobe for the register bus |
| reg_addr | input | 3 | Word address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_i | input | 32 | Per-source event pulses, one bit per source |
| irq_o | output | 3 | Level-sensitive request lines |

## Verification
The hardest case to reach from the ports is a flag-clear write and a new event that land on the same bit in the same clock. Both arrive through separate paths, so ordinary stimulus almost never lines them up. The stimulus table has a row that drives the clear strobe and the event pulse together in one cycle, then checks that the line stays high and the pending view still holds the bit. A second instance built with the other grouping runs the same bus traffic, so each channel is checked against both line layouts.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int LINES = 3;

  typedef enum logic [2:0] {
    A_FLAGS = 3'd0,
    A_MASK  = 3'd1,
    A_PEND  = 3'd2,
    A_MSET  = 3'd3,
    A_MCLR  = 3'd4,
    A_FCLR  = 3'd5
  } reg_addr_e;

  // One-hot line that serves a channel for the given grouping variant
  function automatic logic [LINES-1:0] line_sel(int variant, int ch);
    logic [LINES-1:0] r;
    if (variant == 0) begin
      if (ch == 0)      r = 3'b001;
      else if (ch == 1) r = 3'b010;
      else              r = 3'b100;
    end else begin
      if (ch == 5) r = 3'b001;
      else         r = 3'b010;
    end
    return r;
  endfunction
endpackage

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] evt,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] mask_q
);
  logic [NSRC-1:0] mset, mclr, fclr;

  always_comb begin
    mset = '0;
    mclr = '0;
    fclr = '0;
    if (wr_en) begin
      case (addr)
        A_MSET:  mset = wdata;
        A_MCLR:  mclr = wdata;
        A_FCLR:  fclr = wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      flag_q <= (flag_q & ~fclr) | evt;   // event beats a coincident clear
      mask_q <= (mask_q | mset) & ~mclr;
    end
  end
endmodule

// File: rtl/tmr_irq_route.sv
module tmr_irq_route
  import tmr_irq_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int NCHAN   = 8,
  parameter int VARIANT = 0
) (
  input  logic [NSRC-1:0]  pend,
  output logic [LINES-1:0] irq
);
  function automatic logic [NSRC-1:0] members(int line);
    logic [NSRC-1:0] m;
    logic [LINES-1:0] s;
    m = '0;
    for (int i = 0; i < NSRC; i++) begin
      s = line_sel(VARIANT, i % NCHAN);
      m[i] = s[line];
    end
    return m;
  endfunction

  for (genvar l = 0; l < LINES; l++) begin : g_line
    localparam logic [NSRC-1:0] MEM = members(l);
    assign irq[l] = |(pend & MEM);
  end
endmodule

// File: rtl/tmr_irq_rdmux.sv
module tmr_irq_rdmux
  import tmr_irq_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic [2:0]      addr,
  input  logic [NSRC-1:0] flag_q,
  input  logic [NSRC-1:0] mask_q,
  input  logic [NSRC-1:0] pend,
  output logic [NSRC-1:0] rdata
);
  always_comb begin
    case (addr)
      A_FLAGS: rdata = flag_q;
      A_MASK:  rdata = mask_q;
      A_PEND:  rdata = pend;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int NCHAN   = 8,
  parameter int VARIANT = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [2:0]       reg_addr,
  input  logic [NSRC-1:0]  reg_wdata,
  output logic [NSRC-1:0]  reg_rdata,
  input  logic [NSRC-1:0]  evt_i,
  output logic [LINES-1:0] irq_o
);
  logic [NSRC-1:0] flag_q, mask_q, pend;

  tmr_irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .evt(evt_i), .flag_q(flag_q), .mask_q(mask_q)
  );

  assign pend = flag_q & ~mask_q;

  tmr_irq_route #(.NSRC(NSRC), .NCHAN(NCHAN), .VARIANT(VARIANT)) u_route (
    .pend(pend), .irq(irq_o)
  );

  tmr_irq_rdmux #(.NSRC(NSRC)) u_rd (
    .addr(reg_addr), .flag_q(flag_q), .mask_q(mask_q), .pend(pend),
    .rdata(reg_rdata)
  );
endmodule

// File: rtl/tmr_irq_ctrl_chk.sv
module tmr_irq_ctrl_chk
  import tmr_irq_pkg::*;
#(
  parameter int NSRC    = 32,
  parameter int VARIANT = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr_en,
  input logic [2:0]       reg_addr,
  input logic [NSRC-1:0]  reg_wdata,
  input logic [NSRC-1:0]  reg_rdata,
  input logic [NSRC-1:0]  evt_i,
  input logic [LINES-1:0] irq_o,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  mask_q
);
  logic armed;
  logic [NSRC-1:0] mset_v, mclr_v, fclr_v;

  always_ff @(posedge clk) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign mset_v = (reg_wr_en && reg_addr == A_MSET) ? reg_wdata : '0;
  assign mclr_v = (reg_wr_en && reg_addr == A_MCLR) ? reg_wdata : '0;
  assign fclr_v = (reg_wr_en && reg_addr == A_FCLR) ? reg_wdata : '0;

  assert_mask_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((~$past(mask_q) | mask_q | $past(mclr_v)) == '1));

  assert_mask_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(mask_q) | ~mask_q | $past(mset_v)) == '1));

  assert_flag_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((~$past(flag_q) | flag_q | $past(fclr_v)) == '1));

  assert_event_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (($past(evt_i) & ~flag_q) == '0));

  assert_line_has_pend_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_o) |-> (|(flag_q & ~mask_q)));

  assert_pend_has_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag_q & ~mask_q)) |-> (|irq_o));

  assert_wo_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr >= 3'd3) |-> (reg_rdata == '0));

  assert_line2_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (VARIANT == 1) |-> !irq_o[2]);
endmodule

bind tmr_irq_ctrl tmr_irq_ctrl_chk #(.NSRC(NSRC), .VARIANT(VARIANT)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_i(evt_i),
  .irq_o(irq_o), .flag_q(flag_q), .mask_q(mask_q)
);

// File: tb/tmr_irq_ctrl_test.sv
`timescale 1ns/1ps
module tmr_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] evt = '0;
  logic [31:0] rdata, rdata_b;
  logic [2:0]  irq, irq_b;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  tmr_irq_ctrl #(.VARIANT(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .evt_i(evt), .irq_o(irq)
  );

  tmr_irq_ctrl #(.VARIANT(1)) uut_b (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata_b), .evt_i(evt), .irq_o(irq_b)
  );

  typedef struct packed {
    logic [2:0]  a;
    logic        w;
    logic [31:0] d;
    logic [31:0] e;
    logic [2:0]  xirq;
    logic [31:0] xpend;
  } vec_t;

  // Address codes: 3 mask-set, 4 mask-clear, 5 flag-clear
  localparam vec_t VEC [12] = '{
    '{3'd0, 1'b0, 32'h0,   32'h1,   3'b000, 32'h0},    // R5 masked event
    '{3'd4, 1'b1, 32'h1,   32'h0,   3'b001, 32'h1},    // R3 R5 unmask
    '{3'd4, 1'b1, 32'h104, 32'h0,   3'b001, 32'h1},
    '{3'd0, 1'b0, 32'h0,   32'h100, 3'b001, 32'h101},  // R7 ch0 twice
    '{3'd5, 1'b1, 32'h1,   32'h0,   3'b001, 32'h100},  // R4
    '{3'd5, 1'b1, 32'h100, 32'h0,   3'b000, 32'h0},    // R7 level drops
    '{3'd0, 1'b0, 32'h0,   32'h4,   3'b100, 32'h4},    // R8 shared line
    '{3'd4, 1'b1, 32'h2,   32'h2,   3'b110, 32'h6},    // R8 line1
    '{3'd3, 1'b1, 32'h4,   32'h0,   3'b010, 32'h2},    // R3 mask set
    '{3'd5, 1'b1, 32'h2,   32'h2,   3'b010, 32'h2},    // R6 event wins
    '{3'd5, 1'b1, 32'h2,   32'h0,   3'b000, 32'h0},    // R4
    '{3'd4, 1'b1, 32'h0,   32'h0,   3'b000, 32'h0}     // R3 zero bits
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(logic [2:0] a, logic w, logic [31:0] d, logic [31:0] e);
    @(negedge clk);
    addr = a; wr = w; wdata = d; evt = e;
    @(negedge clk);
    wr = 1'b0; evt = '0; wdata = '0;
  endtask

  task automatic peek(logic [2:0] a);
    addr = a;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr = 1'b0; evt = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    peek(3'd1); check("R1 mask", rdata, 32'hFFFF_FFFF);
    peek(3'd0); check("R1 flags", rdata, 32'h0);
    check("R1 irq", {29'd0, irq}, 32'h0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i].a, VEC[i].w, VEC[i].d, VEC[i].e);
      check($sformatf("R7 irq vec%0d", i), {29'd0, irq}, {29'd0, VEC[i].xirq});
      peek(3'd2);
      check($sformatf("R2 pend vec%0d", i), rdata, VEC[i].xpend);
    end

    peek(3'd1); check("R3 mask after zero write", rdata, 32'hFFFF_FEFC);
    peek(3'd0); check("R2 raw flags", rdata, 32'h4);

    // R5: stored masked flag on bit 2 comes out once unmasked
    step(3'd4, 1'b1, 32'h4, 32'h0);
    check("R5 unmask stored", {29'd0, irq}, 32'h4);

    for (int a = 3; a < 8; a++) begin
      peek(a[2:0]); check("R10 reads zero", rdata, 32'h0);
    end

    // Grouping, both variants, fresh state
    do_reset();
    step(3'd4, 1'b1, 32'hFFFF_FFFF, 32'h0);
    check("R9 idle", {29'd0, irq_b}, 32'h0);
    step(3'd0, 1'b0, 32'h0, 32'h20);
    check("R9 ch5 own line", {29'd0, irq_b}, 32'h1);
    check("R8 ch5 shared", {29'd0, irq}, 32'h4);
    step(3'd0, 1'b0, 32'h0, 32'h0800_0000);   // bit 27, channel 3
    check("R9 ch3 shared", {29'd0, irq_b}, 32'h3);
    step(3'd5, 1'b1, 32'h20, 32'h0);
    check("R9 line2 low", {29'd0, irq_b}, 32'h2);
    step(3'd0, 1'b0, 32'h0, 32'h0200_0000);   // bit 25, channel 1
    check("R8 bit25 line1", {29'd0, irq}, 32'h6);
    peek(3'd2); check("R2 pend B", rdata_b, 32'h0A00_0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule